// File: doc/BRIEF.md
# Pipelined AES-128 Key Schedule Round

This block computes one step of the AES-128 key schedule. It takes a 128-bit round key and produces the round key that follows it. It is built as a fixed-depth pipeline, so it can run in lockstep with a fully pipelined cipher. A fresh key can enter on every clock, and each result leaves a fixed number of cycles later together with a valid flag. A chain of ten such rounds, each with its own `ROUND_IDX`, yields the ten derived round keys. The cipher key itself serves as the round-0 key.

The word-substitution path uses a byte substitution box that is pipelined over seven register stages. The box computes the multiplicative inverse as a chain of squarings and multiplications in GF(2^8), then applies the affine map. Around that path there are two more stages: an input capture register and an output register that forms the chained XOR. The depth is therefore nine sub-stages, which stays within the ten stages of an encryption round. A parameter can add one more alignment register when the consuming AddRoundKey stage needs the key one cycle later.

Top module: `aes_key_round_pipe`

## Requirements
- R1: `in_key` holds four 32-bit words with w0 in bits 127:96, w1 in 95:64, w2 in 63:32 and w3 in 31:0; `out_key` uses the same layout for the new words n0..n3.
- R2: The temporary word is formed from w3 rotated left by one byte: the byte in bits 31:24 moves to bits 7:0 and the other bytes move up by eight bits.
- R3: Each byte of the rotated word is replaced by the AES substitution value: the multiplicative inverse modulo x^8+x^4+x^3+x+1 (0 maps to 0), followed by the affine map with constant 0x63. A zero byte therefore becomes 0x63.
- R4: The round constant is XORed into bits 31:24 of the substituted word. For `ROUND_IDX` 1 to 10 this constant is 01,02,04,08,10,20,40,80,1B,36 (repeated doubling in GF(2^8)), and the three lower bytes are zero.
- R5: The new words are n0 = w0^t, n1 = w1^n0, n2 = w2^n1 and n3 = w3^n2, where t is the temporary word after the round-constant XOR.
- R6: `out_valid` rises exactly 9 cycles after `in_valid` was sampled high (10 cycles when `EXTRA_ALIGN` = 1). Keys presented on consecutive cycles come out on consecutive cycles, and idle input cycles come out as idle output cycles.
- R7: While `rst_n` is low and until new valid keys have passed through the pipeline, `out_valid` stays low. Keys that were in flight when reset was asserted never appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_key` as a key to expand this cycle |
| in_key | input | 128 | Previous round key, words w0..w3 |
| out_valid | output | 1 | Marks `out_key` as a finished round key |
| out_key | output | 128 | Next round key, words n0..n3 |

## Verification
The bench applies the all-zero key, where every byte substitutes to 0x63. A design that skipped the inverse for zero, or dropped the affine constant, would show a wrong pattern in all four words. It also applies the all-ones key and two keys with distinct bytes, which expose a rotation in the wrong direction or an XOR chain fed from the old words instead of the new ones. It streams keys back to back and also sends a single key between idle cycles. A valid pipe that is off by one stage, or that stretches its pulse, would then raise `out_valid` on the wrong cycle. A reset while a key is in flight checks that a design which only reset its data, or not its valid flags, would leak a stale key.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  typedef logic [31:0] word_t;

  // Multiply by x modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // General product in GF(2^8), shift-and-add
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf_sq(input logic [7:0] a);
    return gf_mul(a, a);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  // Affine output map of the substitution box
  function automatic logic [7:0] sbox_affine(input logic [7:0] inv);
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  // Round constant top byte: doubling of 1, (idx-1) times
  function automatic logic [7:0] round_const(input int idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 10; i++) begin
      if (i < idx) r = gf_xtime(r);
    end
    return r;
  endfunction

  // Byte rotation toward the most significant end
  function automatic word_t rot_word(input word_t w);
    return {w[23:0], w[31:24]};
  endfunction

endpackage

// File: rtl/aes_sbox_pipe.sv
// Substitution box with seven register stages.
// Inverse = x^254 built as x^2, x^3, x^12, x^15, x^240, x^252, x^254.
module aes_sbox_pipe (
  input  logic       clk,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import aes_ks_pkg::*;

  logic [7:0] s1_p2, s1_p3;
  logic [7:0] s2_p2, s2_p3, s2_p12;
  logic [7:0] s3_p2, s3_p12, s3_p15;
  logic [7:0] s4_p2, s4_p12, s4_p240;
  logic [7:0] s5_p2, s5_p252;
  logic [7:0] s6_inv;
  logic [7:0] s7_out;

  // stage 1: square and cube
  always_ff @(posedge clk) begin
    s1_p2 <= gf_sq(din);
    s1_p3 <= gf_mul(gf_sq(din), din);
  end

  // stage 2: x^12 = (x^3)^4
  always_ff @(posedge clk) begin
    s2_p2  <= s1_p2;
    s2_p3  <= s1_p3;
    s2_p12 <= gf_sq(gf_sq(s1_p3));
  end

  // stage 3: x^15
  always_ff @(posedge clk) begin
    s3_p2  <= s2_p2;
    s3_p12 <= s2_p12;
    s3_p15 <= gf_mul(s2_p12, s2_p3);
  end

  // stage 4: x^240 = (x^15)^16
  always_ff @(posedge clk) begin
    s4_p2   <= s3_p2;
    s4_p12  <= s3_p12;
    s4_p240 <= gf_sq(gf_sq(gf_sq(gf_sq(s3_p15))));
  end

  // stage 5: x^252
  always_ff @(posedge clk) begin
    s5_p2   <= s4_p2;
    s5_p252 <= gf_mul(s4_p240, s4_p12);
  end

  // stage 6: x^254, the inverse (0 stays 0)
  always_ff @(posedge clk) begin
    s6_inv <= gf_mul(s5_p252, s5_p2);
  end

  // stage 7: affine map
  always_ff @(posedge clk) begin
    s7_out <= sbox_affine(s6_inv);
  end

  assign dout = s7_out;

endmodule

// File: rtl/ks_delay_line.sv
// Plain register delay used to keep the key words beside the substitution path.
module ks_delay_line #(
  parameter int W     = 128,
  parameter int DEPTH = 7
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) sr[0] <= d;

  for (genvar i = 1; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk) sr[i] <= sr[i-1];
  end

  assign q = sr[DEPTH-1];

endmodule

// File: rtl/aes_key_round_pipe.sv
module aes_key_round_pipe #(
  parameter int ROUND_IDX   = 1,
  parameter bit EXTRA_ALIGN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] in_key,
  output logic         out_valid,
  output logic [127:0] out_key
);
  import aes_ks_pkg::*;

  localparam int       SBOX_LAT = 7;
  localparam int       LAT      = 2 + SBOX_LAT + int'(EXTRA_ALIGN);
  localparam int       WARM_W   = $clog2(LAT + 1);
  localparam int       NBYTES   = 4;
  localparam logic [7:0] RCON_B = round_const(ROUND_IDX);

  // stage 0: capture
  logic [127:0] key_s0;
  always_ff @(posedge clk) key_s0 <= in_key;

  // rotated last word into the substitution boxes
  word_t rot_s0, sub_word;
  assign rot_s0 = rot_word(key_s0[31:0]);

  for (genvar b = 0; b < NBYTES; b++) begin : g_sbox
    aes_sbox_pipe u_sbox (
      .clk  (clk),
      .din  (rot_s0[8*b +: 8]),
      .dout (sub_word[8*b +: 8])
    );
  end

  // old words held beside the substitution path
  logic [127:0] key_dly;
  ks_delay_line #(.W(128), .DEPTH(SBOX_LAT)) u_words (
    .clk (clk),
    .d   (key_s0),
    .q   (key_dly)
  );

  // chained XOR, registered
  word_t tmp_word, n0, n1, n2, n3;
  assign tmp_word = sub_word ^ {RCON_B, 24'h000000};
  assign n0 = key_dly[127:96] ^ tmp_word;
  assign n1 = key_dly[95:64]  ^ n0;
  assign n2 = key_dly[63:32]  ^ n1;
  assign n3 = key_dly[31:0]   ^ n2;

  logic [127:0] key_nx;
  always_ff @(posedge clk) key_nx <= {n0, n1, n2, n3};

  // optional alignment stage
  if (EXTRA_ALIGN) begin : g_align
    logic [127:0] key_al;
    always_ff @(posedge clk) key_al <= key_nx;
    assign out_key = key_al;
  end else begin : g_noalign
    assign out_key = key_nx;
  end

  // valid pipeline, the only reset state
  logic [LAT-1:0] vld_sr;
  always_ff @(posedge clk) begin
    if (!rst_n) vld_sr <= '0;
    else        vld_sr <= {vld_sr[LAT-2:0], in_valid};
  end
  assign out_valid = vld_sr[LAT-1];

  // ---------------- assertion support ----------------
  // cycles since reset release, saturating at the pipeline depth
  logic [WARM_W-1:0] warm_cnt;
  logic              primed;
  always_ff @(posedge clk) begin
    if (!rst_n)       warm_cnt <= '0;
    else if (!primed) warm_cnt <= warm_cnt + 1'b1;
  end
  assign primed = (warm_cnt == WARM_W'(LAT));

  // R6: valid flag follows the input flag by exactly LAT cycles
  a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (out_valid == $past(in_valid, LAT)));

  // R7: nothing valid leaves before a full pipeline depth after reset
  a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !out_valid);

  // R5: last two output words differ by the old last word
  a_r5_chain_tail: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> ((out_key[63:32] ^ out_key[31:0]) == $past(in_key[31:0], LAT)));

  // R3/R4: a zero last word substitutes to 63 bytes plus the round constant
  a_r4_zero_word_const: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && ($past(in_key[31:0], LAT) == 32'h0)) |->
      (out_key[127:96] == ($past(in_key[127:96], LAT) ^ {8'h63 ^ RCON_B, 24'h636363})));

endmodule

// File: tb/test_aes_key_round_pipe.sv
`timescale 1ns/1ps
module test_aes_key_round_pipe;

  localparam int LAT  = 9;
  localparam int NVEC = 4;

  // {previous key, expected next key} for round index 1 (constant 01)
  localparam logic [255:0] VEC [NVEC] = '{
    {128'h00000000000000000000000000000000, 128'h62636363626363636263636362636363},
    {128'hffffffffffffffffffffffffffffffff, 128'he8e9e9e917161616e8e9e9e917161616},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'ha0fafe1788542cb123a339392a6c7605},
    {128'h000102030405060708090a0b0c0d0e0f, 128'hd6aa74fdd2af72fadaa678f1d6ab76fe}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_key = '0;
  logic         out_valid;
  logic [127:0] out_key;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  aes_key_round_pipe #(.ROUND_IDX(1), .EXTRA_ALIGN(1'b0)) i_aes_key_round_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
    .out_valid(out_valid), .out_key(out_key)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%032h expected=%032h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%032h expected=%032h", 128'h0, 128'h1);
    finish_run();
  end

  initial begin
    // reset state (R7)
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R7 valid low in reset", {127'h0, out_valid}, 128'h0);
    rst_n = 1'b1;

    // streamed table, one key per cycle (R1..R6)
    for (int m = 0; m < NVEC + LAT + 1; m++) begin
      @(negedge clk);
      if (m >= LAT && m < LAT + NVEC) begin
        check(out_valid == 1'b1, "R6 back-to-back valid", {127'h0, out_valid}, 128'h1);
        check(out_key == VEC[m-LAT][127:0], "R1 R2 R3 R4 R5 next key",
              out_key, VEC[m-LAT][127:0]);
      end else begin
        check(out_valid == 1'b0, "R6 idle cycle stays idle", {127'h0, out_valid}, 128'h0);
      end
      in_valid = (m < NVEC);
      in_key   = (m < NVEC) ? VEC[m][255:128] : 128'h0;
    end

    // single key between idle cycles: exact latency (R6)
    @(negedge clk);
    in_valid = 1'b1;
    in_key   = VEC[2][255:128];
    for (int k = 1; k <= LAT + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        in_valid = 1'b0;
        in_key   = 128'h0;
      end
      if (k == LAT - 1)
        check(out_valid == 1'b0, "R6 not one cycle early", {127'h0, out_valid}, 128'h0);
      if (k == LAT) begin
        check(out_valid == 1'b1, "R6 exact latency", {127'h0, out_valid}, 128'h1);
        check(out_key == VEC[2][127:0], "R5 isolated key", out_key, VEC[2][127:0]);
      end
      if (k == LAT + 1)
        check(out_valid == 1'b0, "R6 pulse not stretched", {127'h0, out_valid}, 128'h0);
    end

    // reset with a key in flight: it must never appear (R7)
    @(negedge clk);
    in_valid = 1'b1;
    in_key   = VEC[3][255:128];
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R7 valid low during reset", {127'h0, out_valid}, 128'h0);
    rst_n = 1'b1;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < LAT + 3; k++) begin
        @(negedge clk);
        if (out_valid) seen = 1'b1;
      end
      check(seen == 1'b0, "R7 in-flight key discarded", {127'h0, seen}, 128'h0);
    end

    finish_run();
  end

endmodule